// File: doc/BRIEF.md
# Register-Mask Stack Offset Generator

This block takes a 16-bit register-select mask, one bit per register of a multiple-register transfer, and produces a byte offset ready to add to a stack pointer. The offset is minus four times the number of selected registers. It is the distance from the current top of the stack down to the lowest word the transfer touches. Address logic can therefore begin at the lowest address and walk upward without first counting the registers some other way.

The count comes from a carry-save tree of three-input adders. The last adder row adds one extra in every column, so the tree yields the count minus one. That value is inverted, sign-extended and moved up by the register byte-size exponent. The result is the two's complement negative offset. The result is combinational. It is driven onto the output only while the enable from sequencing control is high, and the output is zero at all other times.

Top module: `regmask_offset_gen`

## Requirements
- R1: With `drive_en` = 1, `bus_offset` equals −4 × (number of ones in `sel_mask`) as a 32-bit two's complement value, for every one of the 65536 masks.
- R2: With `drive_en` = 0, `bus_offset` is 0 whatever `sel_mask` holds.
- R3: With `drive_en` = 1 and `sel_mask` = 0x0000, `bus_offset` is 0x00000000.
- R4: With `drive_en` = 1 and `sel_mask` = 0xFFFF, `bus_offset` is 0xFFFFFFC0 (−64), so a full mask of sixteen is representable.
- R5: Bits [1:0] of `bus_offset` are always 0, because the offset is a whole number of 4-byte words.
- R6: Bits [31:6] of `bus_offset` all carry the same value, because the 5-bit negative count is sign-extended.
- R7: With `drive_en` = 1 and exactly one bit of `sel_mask` set, in any of the 16 positions, `bus_offset` is 0xFFFFFFFC (−4).
- R8: The output has no storage. A new mask or enable value appears on `bus_offset` in the same clock cycle in which it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_mask | input | 16 | Register-select mask, bit i selects register i |
| drive_en | input | 1 | Output enable from sequencing control |
| bus_offset | output | 32 | −4 × popcount(sel_mask) while enabled, else 0 |

## Verification
The block contains no registers, so every result is due in the same cycle as the stimulus that causes it. The bench changes `sel_mask` and `drive_en` one nanosecond after a rising edge. It samples `bus_offset` one nanosecond later, inside the same 4 ns cycle and well clear of both edges. This gives every mask a whole cycle to itself, and no sample is taken while an input is changing. The sweep covers all 65536 masks with the enable high. It then covers a spread of masks with the enable low, to confirm that the mask has no effect on the output while it is not driven.

// File: rtl/rmo_pkg.sv
package rmo_pkg;
   // Width of the register-select mask the adder tree is laid out for.
   localparam int unsigned TREE_MASK_W = 16;
   // Columns of weight 1, 2, 4 and 8 leaving the carry-save tree.
   localparam int unsigned COL_W       = 4;
   // Signed negative count: the column bits plus one sign bit.
   localparam int unsigned NEG_W       = COL_W + 1;
   // Full adders in the first row; each sums a triple of mask bits.
   localparam int unsigned ROW1_CELLS  = TREE_MASK_W / 3;

   // Adder cell implementation variants.
   typedef enum int unsigned {
      FA_MUX  = 0,   // built from 2:1 selectors
      FA_GATE = 1    // plain XOR / majority gates
   } fa_style_e;

   // Sum and carry pair leaving one adder cell.
   typedef struct packed {
      logic carry;
      logic sum;
   } cs_pair_t;
endpackage

// File: rtl/rmo_full_add.sv
module rmo_full_add
   import rmo_pkg::*;
#(
   parameter fa_style_e STYLE = FA_MUX
) (
   input  logic     a,
   input  logic     b,
   input  logic     ci,
   output cs_pair_t res
);
   generate
      if (STYLE == FA_MUX) begin : g_mux
         logic x_ab;     // a differs from b
         logic x_ab_n;
         always_comb begin
            // selector on b picks a or its inverse
            x_ab   = b ? ~a : a;
            x_ab_n = ~x_ab;
            // selector on the difference picks the sum polarity
            res.sum   = x_ab ? ~ci : ci;
            // when a and b differ the carry follows ci, else it equals a
            res.carry = x_ab_n ? a : ci;
         end
      end else begin : g_gate
         always_comb begin
            res.sum   = a ^ b ^ ci;
            res.carry = (a & b) | (a & ci) | (b & ci);
         end
      end
   endgenerate
endmodule

// File: rtl/rmo_csa_tree.sv
module rmo_csa_tree
   import rmo_pkg::*;
#(
   parameter fa_style_e STYLE = FA_MUX
) (
   input  logic [TREE_MASK_W-1:0] mask,
   output logic [COL_W-1:0]       col,    // one bit per weight column
   output logic                   col0_b  // second bit of the weight-1 column
);
   // Row 1: triples of mask bits.
   cs_pair_t row1 [ROW1_CELLS];

   genvar gi;
   generate
      for (gi = 0; gi < ROW1_CELLS; gi++) begin : g_row1
         rmo_full_add #(.STYLE(STYLE)) u_fa (
            .a  (mask[3*gi]),
            .b  (mask[3*gi+1]),
            .ci (mask[3*gi+2]),
            .res(row1[gi])
         );
      end
   endgenerate

   // Weight-1 column: five row-1 sums plus the leftover mask bit.
   cs_pair_t w1_a, w1_b;
   rmo_full_add #(.STYLE(STYLE)) u_w1_a (
      .a(row1[0].sum), .b(row1[1].sum), .ci(row1[2].sum), .res(w1_a));
   rmo_full_add #(.STYLE(STYLE)) u_w1_b (
      .a(row1[3].sum), .b(row1[4].sum), .ci(mask[TREE_MASK_W-1]), .res(w1_b));

   // Weight-2 column: five row-1 carries plus two carries from weight 1.
   cs_pair_t w2_a, w2_b, w2_c;
   rmo_full_add #(.STYLE(STYLE)) u_w2_a (
      .a(row1[0].carry), .b(row1[1].carry), .ci(row1[2].carry), .res(w2_a));
   rmo_full_add #(.STYLE(STYLE)) u_w2_b (
      .a(row1[3].carry), .b(row1[4].carry), .ci(w1_a.carry), .res(w2_b));
   rmo_full_add #(.STYLE(STYLE)) u_w2_c (
      .a(w2_a.sum), .b(w2_b.sum), .ci(w1_b.carry), .res(w2_c));

   // Weight-4 column: the three carries produced in the weight-2 column.
   cs_pair_t w4_a;
   rmo_full_add #(.STYLE(STYLE)) u_w4_a (
      .a(w2_a.carry), .b(w2_b.carry), .ci(w2_c.carry), .res(w4_a));

   always_comb begin
      col[0] = w1_a.sum;
      col0_b = w1_b.sum;
      col[1] = w2_c.sum;
      col[2] = w4_a.sum;
      col[3] = w4_a.carry;   // the only weight-8 bit
   end
endmodule

// File: rtl/rmo_inc_half.sv
module rmo_inc_half (
   input  logic a,
   input  logic b,
   output logic s,
   output logic co
);
   // Computes a + b + 1: the sum bit is the inverse of a XOR b,
   // and a carry leaves whenever either input is set.
   always_comb begin
      s  = ~(a ^ b);
      co = a | b;
   end
endmodule

// File: rtl/rmo_dec_chain.sv
module rmo_dec_chain
   import rmo_pkg::*;
(
   input  logic [COL_W-1:0] col,
   input  logic             col0_b,
   output logic [COL_W-1:0] cm1,     // low bits of count - 1
   output logic             nz       // carry out: the count is non-zero
);
   logic [COL_W-1:0] second;
   logic [COL_W-1:0] cy;

   genvar gk;
   generate
      for (gk = 0; gk < COL_W; gk++) begin : g_col
         if (gk == 0) begin : g_first
            always_comb second[gk] = col0_b;
         end else begin : g_rest
            always_comb second[gk] = cy[gk-1];
         end
         rmo_inc_half u_ha (
            .a (col[gk]),
            .b (second[gk]),
            .s (cm1[gk]),
            .co(cy[gk])
         );
      end
   endgenerate

   always_comb nz = cy[COL_W-1];
endmodule

// File: rtl/rmo_scale_drive.sv
module rmo_scale_drive
   import rmo_pkg::*;
#(
   parameter int unsigned OUT_W = 32,
   parameter int unsigned SHIFT = 2
) (
   input  logic [COL_W-1:0] cm1,
   input  logic             nz,
   input  logic             en,
   output logic [OUT_W-1:0] bus
);
   localparam int unsigned EXT_W = OUT_W - NEG_W - SHIFT;

   logic [NEG_W-1:0] neg_cnt;
   logic [OUT_W-1:0] placed;

   // Inverting count - 1 gives -count; the carry out becomes the sign.
   always_comb neg_cnt = {nz, ~cm1};

   generate
      if (SHIFT == 0) begin : g_noshift
         if (EXT_W == 0) begin : g_exact
            always_comb placed = neg_cnt;
         end else begin : g_ext
            always_comb placed = {{EXT_W{neg_cnt[NEG_W-1]}}, neg_cnt};
         end
      end else begin : g_shift
         if (EXT_W == 0) begin : g_exact
            always_comb placed = {neg_cnt, {SHIFT{1'b0}}};
         end else begin : g_ext
            always_comb placed = {{EXT_W{neg_cnt[NEG_W-1]}}, neg_cnt, {SHIFT{1'b0}}};
         end
      end
   endgenerate

   always_comb bus = en ? placed : '0;
endmodule

// File: rtl/regmask_offset_gen.sv
module regmask_offset_gen
   import rmo_pkg::*;
#(
   parameter int unsigned MASK_W   = 16,
   parameter int unsigned OUT_W    = 32,
   parameter int unsigned SHIFT    = 2,
   parameter fa_style_e   FA_STYLE = FA_MUX
) (
   input  logic [MASK_W-1:0] sel_mask,
   input  logic              drive_en,
   output logic [OUT_W-1:0]  bus_offset
);
   localparam int unsigned MIN_OUT_W = NEG_W + SHIFT;

   generate
      if (MASK_W != TREE_MASK_W) begin : g_bad_mask
         $error("regmask_offset_gen: MASK_W must equal the tree width 16");
      end
      if (OUT_W < MIN_OUT_W) begin : g_bad_out
         $error("regmask_offset_gen: OUT_W too narrow for the scaled count");
      end
   endgenerate

   logic [COL_W-1:0] col;
   logic             col0_b;
   logic [COL_W-1:0] cm1;
   logic             nz;

   rmo_csa_tree #(.STYLE(FA_STYLE)) u_tree (
      .mask  (sel_mask),
      .col   (col),
      .col0_b(col0_b)
   );

   rmo_dec_chain u_dec (
      .col   (col),
      .col0_b(col0_b),
      .cm1   (cm1),
      .nz    (nz)
   );

   rmo_scale_drive #(.OUT_W(OUT_W), .SHIFT(SHIFT)) u_drive (
      .cm1(cm1),
      .nz (nz),
      .en (drive_en),
      .bus(bus_offset)
   );
endmodule

// File: rtl/regmask_offset_gen_chk.sv
module regmask_offset_gen_chk #(
   parameter int unsigned MASK_W = 16,
   parameter int unsigned OUT_W  = 32,
   parameter int unsigned SHIFT  = 2
) (
   input logic [MASK_W-1:0] sel_mask,
   input logic              drive_en,
   input logic [OUT_W-1:0]  bus_offset
);
   logic [OUT_W-1:0] ref_val;
   always_comb ref_val = OUT_W'(-(($countones(sel_mask)) << SHIFT));

   always_comb begin
      if (!drive_en) begin
         assert_idle_zero_R2: assert (bus_offset == '0)
            else $error("idle bus not zero");
      end else begin
         assert_offset_value_R1: assert (bus_offset == ref_val)
            else $error("offset mismatch");
         if (sel_mask == '0) begin
            assert_empty_mask_R3: assert (bus_offset == '0)
               else $error("empty mask not zero");
         end
         if (&sel_mask) begin
            assert_full_mask_R4: assert (bus_offset == 32'hFFFF_FFC0)
               else $error("full mask wrong");
         end
         if ($countones(sel_mask) == 1) begin
            assert_single_bit_R7: assert (bus_offset == 32'hFFFF_FFFC)
               else $error("single bit wrong");
         end
      end
      assert_word_align_R5: assert (bus_offset[1:0] == 2'b00)
         else $error("offset not word aligned");
      assert_sign_ext_R6: assert ((bus_offset[31:6] == '0) || (&bus_offset[31:6]))
         else $error("sign extension broken");
   end
endmodule

bind regmask_offset_gen regmask_offset_gen_chk #(
   .MASK_W(MASK_W), .OUT_W(OUT_W), .SHIFT(SHIFT)
) u_chk (
   .sel_mask  (sel_mask),
   .drive_en  (drive_en),
   .bus_offset(bus_offset)
);

// File: tb/test_regmask_offset_gen.sv
`timescale 1ns/1ps
module test_regmask_offset_gen;
   localparam int WATCHDOG = 200000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] sel_mask = '0;
   logic        drive_en = 1'b0;
   logic [31:0] bus_offset;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   regmask_offset_gen i_regmask_offset_gen (
      .sel_mask  (sel_mask),
      .drive_en  (drive_en),
      .bus_offset(bus_offset)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s mask=%h en=%b actual=%h expected=%h", req, sel_mask, drive_en, act, exp);
      end
   endtask

   function automatic logic [31:0] expect_off(input logic [15:0] m);
      int n = 0;
      for (int b = 0; b < 16; b++) n += m[b];
      return 32'(-(4 * n));
   endfunction

   // Apply stimulus 1 ns after a rising edge; R8: no storage, so the
   // result is sampled 1 ns later in the same cycle.
   task automatic apply(input logic [15:0] m, input logic en);
      @(posedge clk);
      #1;
      sel_mask = m;
      drive_en = en;
      #1;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles >= WATCHDOG && !done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL R8 watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // Reset state: enable held low while reset is active (R2).
      repeat (3) @(posedge clk);
      #1;
      check("R2", bus_offset, 32'h0);
      rst = 1'b0;

      // R8: an enable edge shows in the same cycle.
      apply(16'h0007, 1'b1);
      check("R8", bus_offset, 32'hFFFF_FFF4);
      apply(16'h0007, 1'b0);
      check("R8", bus_offset, 32'h0);

      // Full sweep with the enable high.
      for (int v = 0; v < 65536; v++) begin
         logic [15:0] m;
         logic [31:0] e;
         m = 16'(v);
         e = expect_off(m);
         apply(m, 1'b1);
         if (m == 16'h0000)          check("R3", bus_offset, 32'h0);
         else if (m == 16'hFFFF)     check("R4", bus_offset, 32'hFFFF_FFC0);
         else if ($countones(m) == 1) check("R7", bus_offset, 32'hFFFF_FFFC);
         else                        check("R1", bus_offset, e);
         check("R5", {30'h0, bus_offset[1:0]}, 32'h0);
         check("R6", {31'h0, !((bus_offset[31:6] == '0) || (&bus_offset[31:6]))}, 32'h0);
      end

      // Enable low: the mask must leave the output at zero (R2).
      for (int v = 0; v < 65536; v += 257) begin
         apply(16'(v), 1'b0);
         check("R2", bus_offset, 32'h0);
      end
      apply(16'hFFFF, 1'b0);
      check("R2", bus_offset, 32'h0);

      // Back to enabled, with no state carried over (R8).
      apply(16'h8001, 1'b1);
      check("R8", bus_offset, 32'hFFFF_FFF8);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule